// File: doc/BRIEF.md
# Split-Access Hypervisor Configuration Register

This block holds one 64-bit hypervisor configuration word. Software can reach it three ways. A full-width port replaces all 64 bits. A low alias port covers bits [31:0], and a high alias port covers bits [63:32]. A write through an alias changes only its own half and merges it with the current contents of the other half. Each view has its own read output, taken from the single stored word.

Three control bits decide how address translation behaves: bit 0 (stage-2 enable), bit 2 (walk protection) and bit 12 (default cacheable). When an accepted write changes any of them, the block raises a one-cycle request on `flush_req` so that a translation cache can flush. Two build options shape the block. One decides whether the hypervisor level exists; without it, every view reads as zero and every write is dropped. The other decides whether the high alias exists; it is absent in older architecture configurations. An auxiliary 32-bit control alias is also provided. It always reads as zero and ignores writes.

Top module: `hyp_cfg_reg`

## Requirements
- R1: After reset the stored word is all zeros, every read view returns zero and `flush_req` is 0.
- R2: A full-width write replaces all 64 bits, and the new value is visible on `full_rdata` after the next rising clock edge.
- R3: A low-alias write replaces bits [31:0] and leaves bits [63:32] unchanged.
- R4: A high-alias write replaces bits [63:32] and leaves bits [31:0] unchanged.
- R5: If a full-width write and an alias write arrive in the same cycle, the full-width write decides the result. A low and a high alias write in the same cycle (with no full write) both take effect.
- R6: `flush_req` is 1 for exactly the cycle after the clock edge that stores a value differing from the old word in bit 0, bit 2 or bit 12. The comparison uses the full merged 64-bit value.
- R7: A write that leaves bits 0, 2 and 12 unchanged does not raise `flush_req`, even if other bits change. Without a write, `flush_req` stays 0.
- R8: `lo_rdata` always equals bits [31:0] of the stored word. `hi_rdata` equals bits [63:32] when the high alias is present.
- R9: When the high alias is not present (HIGH_ALIAS_PRESENT=0), `hi_rdata` reads zero and high-alias writes change nothing.
- R10: When the hypervisor level is absent (HYP_PRESENT=0), all views read zero, all writes are ignored and `flush_req` never rises.
- R11: The auxiliary alias always reads zero, and writes to it change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_we | input | 1 | Full-width write enable |
| full_wdata | input | 64 | Full-width write data |
| lo_we | input | 1 | Low alias write enable |
| lo_wdata | input | 32 | Low alias write data (bits 31:0) |
| hi_we | input | 1 | High alias write enable |
| hi_wdata | input | 32 | High alias write data (bits 63:32) |
| aux_we | input | 1 | Auxiliary alias write enable (ignored) |
| aux_wdata | input | 32 | Auxiliary alias write data (ignored) |
| full_rdata | output | 64 | Full-width read view |
| lo_rdata | output | 32 | Low alias read view |
| hi_rdata | output | 32 | High alias read view |
| aux_rdata | output | 32 | Auxiliary alias read view, always zero |
| flush_req | output | 1 | One-cycle translation-cache flush request |

## Verification
In a single cycle, a full-width write can collide with an alias write, and a low alias write can coincide with a high alias write. The bench drives both cases from its vector table by asserting the enables together. It then checks the stored word against the rule that the full write wins and that two alias halves merge together. The flush decision for each of these combined writes is judged against the whole resulting word, not against a single half.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
   typedef enum logic [1:0] {
      WSRC_NONE   = 2'd0,
      WSRC_FULL   = 2'd1,
      WSRC_HALVES = 2'd2
   } wsrc_e;
endpackage

// File: rtl/hcr_merge.sv
module hcr_merge import hcr_pkg::*; #(
   parameter int W    = 64,
   parameter int HALF = W / 2
) (
   input  logic [W-1:0]    cur,
   input  logic            full_we,
   input  logic [W-1:0]    full_d,
   input  logic            lo_we,
   input  logic [HALF-1:0] lo_d,
   input  logic            hi_we,
   input  logic [HALF-1:0] hi_d,
   output logic [W-1:0]    nxt,
   output wsrc_e           src
);
   always_comb begin
      nxt = cur;
      src = WSRC_NONE;
      if (full_we) begin
         nxt = full_d;
         src = WSRC_FULL;
      end else if (lo_we || hi_we) begin
         if (lo_we) nxt[HALF-1:0] = lo_d;
         if (hi_we) nxt[W-1:HALF] = hi_d;
         src = WSRC_HALVES;
      end
   end
endmodule

// File: rtl/hcr_flush_cmp.sv
module hcr_flush_cmp #(
   parameter int W       = 64,
   parameter int VM_BIT  = 0,
   parameter int PTW_BIT = 2,
   parameter int DC_BIT  = 12
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] nxt,
   input  logic         wr,
   output logic         hit
);
   localparam logic [W-1:0] MASK = (W'(1) << VM_BIT) | (W'(1) << PTW_BIT) | (W'(1) << DC_BIT);
   assign hit = wr && (((cur ^ nxt) & MASK) != '0);
endmodule

// File: rtl/hcr_store.sv
module hcr_store #(
   parameter int W       = 64,
   parameter bit PRESENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] nxt,
   input  logic         hit,
   output logic [W-1:0] q,
   output logic         flush
);
   generate
      if (PRESENT) begin : g_real
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= '0;
               flush <= 1'b0;
            end else begin
               if (wr) q <= nxt;
               flush <= hit;
            end
         end
      end else begin : g_raz
         logic unused_store_in;
         assign unused_store_in = ^{clk, rst_n, wr, nxt, hit};
         assign q     = '0;
         assign flush = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hyp_cfg_reg.sv
module hyp_cfg_reg import hcr_pkg::*; #(
   parameter int W                  = 64,
   parameter int AUX_W              = 32,
   parameter bit HYP_PRESENT        = 1'b1,
   parameter bit HIGH_ALIAS_PRESENT = 1'b1,
   parameter int VM_BIT             = 0,
   parameter int PTW_BIT            = 2,
   parameter int DC_BIT             = 12,
   localparam int HALF              = W / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            full_we,
   input  logic [W-1:0]    full_wdata,
   input  logic            lo_we,
   input  logic [HALF-1:0] lo_wdata,
   input  logic            hi_we,
   input  logic [HALF-1:0] hi_wdata,
   input  logic            aux_we,
   input  logic [AUX_W-1:0] aux_wdata,
   output logic [W-1:0]    full_rdata,
   output logic [HALF-1:0] lo_rdata,
   output logic [HALF-1:0] hi_rdata,
   output logic [AUX_W-1:0] aux_rdata,
   output logic            flush_req
);
   generate
      if (W % 2 != 0) begin : g_bad_w
         $error("hyp_cfg_reg: W must be even");
      end
      if (VM_BIT >= W || PTW_BIT >= W || DC_BIT >= W) begin : g_bad_bit
         $error("hyp_cfg_reg: control bit outside register");
      end
   endgenerate

   logic [W-1:0] cur_q;
   logic [W-1:0] nxt_v;
   wsrc_e        src;
   logic         wr;
   logic         hit;
   logic         hi_we_eff;

   generate
      if (HIGH_ALIAS_PRESENT) begin : g_hi
         assign hi_we_eff = hi_we;
         assign hi_rdata  = cur_q[W-1:HALF];
      end else begin : g_no_hi
         assign hi_we_eff = 1'b0;
         assign hi_rdata  = '0;
      end
   endgenerate

   hcr_merge #(.W(W), .HALF(HALF)) u_merge (
      .cur(cur_q), .full_we(full_we), .full_d(full_wdata),
      .lo_we(lo_we), .lo_d(lo_wdata), .hi_we(hi_we_eff), .hi_d(hi_wdata),
      .nxt(nxt_v), .src(src)
   );

   assign wr = (src != WSRC_NONE);

   hcr_flush_cmp #(.W(W), .VM_BIT(VM_BIT), .PTW_BIT(PTW_BIT), .DC_BIT(DC_BIT)) u_cmp (
      .cur(cur_q), .nxt(nxt_v), .wr(wr), .hit(hit)
   );

   hcr_store #(.W(W), .PRESENT(HYP_PRESENT)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(wr), .nxt(nxt_v), .hit(hit),
      .q(cur_q), .flush(flush_req)
   );

   logic unused_aux_bits;
   assign unused_aux_bits = ^{aux_we, aux_wdata};

   assign full_rdata = cur_q;
   assign lo_rdata   = cur_q[HALF-1:0];
   assign aux_rdata  = '0;
endmodule

// File: rtl/hyp_cfg_reg_chk.sv
module hyp_cfg_reg_chk #(
   parameter int W                  = 64,
   parameter int AUX_W              = 32,
   parameter bit HYP_PRESENT        = 1'b1,
   parameter bit HIGH_ALIAS_PRESENT = 1'b1,
   parameter int VM_BIT             = 0,
   parameter int PTW_BIT            = 2,
   parameter int DC_BIT             = 12,
   localparam int HALF              = W / 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            full_we,
   input logic [W-1:0]    full_wdata,
   input logic            lo_we,
   input logic            hi_we,
   input logic [W-1:0]    full_rdata,
   input logic [HALF-1:0] lo_rdata,
   input logic [HALF-1:0] hi_rdata,
   input logic [AUX_W-1:0] aux_rdata,
   input logic            flush_req
);
   localparam logic [W-1:0] MASK = (W'(1) << VM_BIT) | (W'(1) << PTW_BIT) | (W'(1) << DC_BIT);

   p_quiet_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_we || lo_we || hi_we) |=> !flush_req);

   p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_we || lo_we || hi_we) |=> $stable(full_rdata));

   p_lo_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rdata == full_rdata[HALF-1:0]);

   p_aux_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      aux_rdata == '0);

   generate
      if (HYP_PRESENT) begin : g_hyp
         p_full_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            full_we |=> full_rdata == $past(full_wdata));
         p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_we && !full_we && !hi_we) |=> full_rdata[W-1:HALF] == $past(full_rdata[W-1:HALF]));
         p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_we && !full_we && !lo_we) |=> full_rdata[HALF-1:0] == $past(full_rdata[HALF-1:0]));
         p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req |-> ((full_rdata ^ $past(full_rdata)) & MASK) != '0);
      end else begin : g_nohyp
         p_raz_r10: assert property (@(posedge clk) disable iff (!rst_n)
            full_rdata == '0 && !flush_req);
      end
      if (!HIGH_ALIAS_PRESENT) begin : g_nohi
         p_hi_raz_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hi_rdata == '0);
      end
   endgenerate
endmodule

bind hyp_cfg_reg hyp_cfg_reg_chk #(
   .W(W), .AUX_W(AUX_W), .HYP_PRESENT(HYP_PRESENT), .HIGH_ALIAS_PRESENT(HIGH_ALIAS_PRESENT),
   .VM_BIT(VM_BIT), .PTW_BIT(PTW_BIT), .DC_BIT(DC_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .full_we(full_we), .full_wdata(full_wdata),
   .lo_we(lo_we), .hi_we(hi_we), .full_rdata(full_rdata), .lo_rdata(lo_rdata),
   .hi_rdata(hi_rdata), .aux_rdata(aux_rdata), .flush_req(flush_req)
);

// File: tb/hyp_cfg_reg_test.sv
module hyp_cfg_reg_test;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 9;

   typedef struct packed {
      logic        fwe;
      logic [63:0] fd;
      logic        lwe;
      logic [31:0] ld;
      logic        hwe;
      logic [31:0] hd;
      logic [63:0] exp_q;
      logic        exp_fl;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 64'h0000_0001_0000_0000, 1'b0, 32'h0, 1'b0, 32'h0, 64'h0000_0001_0000_0000, 1'b0},
      '{1'b0, 64'h0, 1'b1, 32'h0000_0001, 1'b0, 32'h0, 64'h0000_0001_0000_0001, 1'b1},
      '{1'b0, 64'h0, 1'b0, 32'h0, 1'b1, 32'hABCD_0000, 64'hABCD_0000_0000_0001, 1'b0},
      '{1'b0, 64'h0, 1'b1, 32'h0000_1001, 1'b0, 32'h0, 64'hABCD_0000_0000_1001, 1'b1},
      '{1'b0, 64'h0, 1'b1, 32'h0000_1001, 1'b0, 32'h0, 64'hABCD_0000_0000_1001, 1'b0},
      '{1'b1, 64'h1234_5678_0000_1005, 1'b0, 32'h0, 1'b0, 32'h0, 64'h1234_5678_0000_1005, 1'b1},
      '{1'b1, 64'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 64'h0, 1'b1},
      '{1'b0, 64'h0, 1'b1, 32'h0000_0004, 1'b1, 32'h0000_0055, 64'h0000_0055_0000_0004, 1'b1},
      '{1'b0, 64'h0, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, 64'hFFFF_FFFF_0000_0004, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0, aux_we = 1'b0;
   logic [63:0] full_wdata = '0;
   logic [31:0] lo_wdata = '0, hi_wdata = '0, aux_wdata = '0;

   logic [63:0] q, q7, qn;
   logic [31:0] lo, hi, aux, lo7, hi7, aux7, lon, hin, auxn;
   logic        fl, fl7, fln;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hyp_cfg_reg uut (
      .clk(clk), .rst_n(rst_n), .full_we(full_we), .full_wdata(full_wdata),
      .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
      .aux_we(aux_we), .aux_wdata(aux_wdata), .full_rdata(q), .lo_rdata(lo),
      .hi_rdata(hi), .aux_rdata(aux), .flush_req(fl)
   );

   hyp_cfg_reg #(.HIGH_ALIAS_PRESENT(1'b0)) uut_v7 (
      .clk(clk), .rst_n(rst_n), .full_we(full_we), .full_wdata(full_wdata),
      .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
      .aux_we(aux_we), .aux_wdata(aux_wdata), .full_rdata(q7), .lo_rdata(lo7),
      .hi_rdata(hi7), .aux_rdata(aux7), .flush_req(fl7)
   );

   hyp_cfg_reg #(.HYP_PRESENT(1'b0)) uut_nohyp (
      .clk(clk), .rst_n(rst_n), .full_we(full_we), .full_wdata(full_wdata),
      .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
      .aux_we(aux_we), .aux_wdata(aux_wdata), .full_rdata(qn), .lo_rdata(lon),
      .hi_rdata(hin), .aux_rdata(auxn), .flush_req(fln)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      full_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0; aux_we = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
   endtask

   initial begin
      do_reset();
      // R1 reset state
      check("R1 full", q, 64'h0);
      check("R1 lo/hi", {hi, lo}, 64'h0);
      check("R1 flush", {63'h0, fl}, 64'h0);

      // vector walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         full_we = VEC[i].fwe; full_wdata = VEC[i].fd;
         lo_we = VEC[i].lwe;   lo_wdata = VEC[i].ld;
         hi_we = VEC[i].hwe;   hi_wdata = VEC[i].hd;
         step();
         idle();
         check($sformatf("R2-vec%0d stored", i), q, VEC[i].exp_q);
         check($sformatf("R6-vec%0d flush", i), {63'h0, fl}, {63'h0, VEC[i].exp_fl});
         check($sformatf("R8-vec%0d views", i), {hi, lo}, VEC[i].exp_q);
      end

      // R6: pulse lasts one cycle
      lo_we = 1'b1; lo_wdata = 32'h0000_0000;
      step(); idle();
      check("R6 pulse set", {63'h0, fl}, 64'h1);
      step();
      check("R6 pulse ends", {63'h0, fl}, 64'h0);
      // R7: no write, no flush, value held
      check("R7 idle hold", q, 64'hFFFF_FFFF_0000_0000);

      // R11: aux writes ignored
      aux_we = 1'b1; aux_wdata = 32'hDEAD_BEEF;
      step(); idle();
      check("R11 aux reads zero", {32'h0, aux}, 64'h0);
      check("R11 reg untouched", q, 64'hFFFF_FFFF_0000_0000);
      check("R11 no flush", {63'h0, fl}, 64'h0);

      // R9 and R10 on the variant instances
      do_reset();
      hi_we = 1'b1; hi_wdata = 32'h0000_0077;
      step(); idle();
      check("R9 hi write ignored", q7, 64'h0);
      check("R9 hi view zero", {32'h0, hi7}, 64'h0);
      check("R4 hi write applied", q, 64'h0000_0077_0000_0000);
      lo_we = 1'b1; lo_wdata = 32'h0000_1005;
      step(); idle();
      check("R9 lo still works", {32'h0, lo7}, 64'h1005);
      check("R9 flush on lo", {63'h0, fl7}, 64'h1);
      full_we = 1'b1; full_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
      step(); idle();
      check("R10 full zero", qn, 64'h0);
      check("R10 views zero", {hin, lon}, 64'h0);
      check("R10 no flush", {63'h0, fln}, 64'h0);
      check("R2 full write", q, 64'hFFFF_FFFF_FFFF_FFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule